// File: doc/BRIEF.md
# Flyback Fault Supervisor Sequencer

This block is the digital fault supervisor of a primary-side switching controller. Once per switching cycle it reads comparator flags: output over-voltage, line run and line stop current, current-sense over-current, current-sense minimum level, and over-temperature. It also reads the drive request from the PWM generator, a strobe that marks the end of leading-edge blanking, a strobe that marks the end of transformer demagnetization, and the VDD turn-on and turn-off flags. From these it decides whether switching is allowed, and it gates the drive output.

Each fault source has its own qualification rule. Over-voltage, line stop and over-current each need several consecutive cycles. The line run current must appear within a start-up window. The current-sense minimum check runs on the first drive pulse after power-on and never again. Over-temperature acts at once. Any qualified fault stops switching and starts a restart sequence: the block waits for VDD to collapse, returns to the waiting state, and resumes when VDD recovers. A 3-bit register records the cause of the latest fault.

Top module: `flyback_fault_seq`

## Requirements
- R1: After reset `sw_en` is 0, `drv` is 0 and `fault_cause` is 0. The block waits for `vdd_on`.
- R2: In the waiting state, `vdd_on` enables switching (`sw_en`=1) from the next clock. After a fault, `sw_en` stays 0 and `vdd_on` is ignored until `vdd_off` has been seen. Only then does a later `vdd_on` enable switching again.
- R3: `drv` follows `drv_req` only while switching is enabled. It is forced to 0 in the same clock in which a fault is decided.
- R4: A switching cycle ends with the clock in which `demag_end` is high. A flag counts for that cycle if it is high in any clock of the cycle, including the `demag_end` clock. Over-voltage in three consecutive cycles is a fault. One cycle without it resets the count.
- R5: After switching is enabled, `line_run` must be seen within the first three cycles. If the third cycle ends without it ever having been seen, that is a fault.
- R6: Once `line_run` has been seen, `line_stop` in three consecutive cycles is a fault.
- R7: `ocp_flag` counts only from the clock after `blank_done` through the clock before `demag_end`. A high level in the `blank_done` clock, before it, or in the `demag_end` clock has no effect.
- R8: Qualified over-current in three consecutive cycles is a fault.
- R9: On the first drive pulse after reset only, `cs_min` must be high within 625 clocks, counting the clock in which `drv_req` rises. If it is not, the fault is decided in the 626th clock. Later pulses are not checked.
- R10: `otp_flag` while switching is a fault in that same clock. If the flag is still high when switching resumes, the fault repeats.
- R11: Cause codes are 1 over-temperature, 2 current-sense minimum, 3 over-current, 4 over-voltage, 5 line. When several faults qualify in one clock, the lowest code is recorded.
- R12: All consecutive-cycle counts and the start-up window are cleared by a fault and while switching is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovp_flag | input | 1 | Output over-voltage comparator |
| line_run | input | 1 | Line current above run level |
| line_stop | input | 1 | Line current below stop level |
| ocp_flag | input | 1 | Current-sense over-current comparator |
| cs_min | input | 1 | Current-sense minimum level reached |
| otp_flag | input | 1 | Over-temperature comparator |
| drv_req | input | 1 | Drive request from the PWM generator |
| blank_done | input | 1 | Strobe: leading-edge blanking ended |
| demag_end | input | 1 | Strobe: demagnetization ended, closes a cycle |
| vdd_on | input | 1 | VDD reached the turn-on level |
| vdd_off | input | 1 | VDD fell to the turn-off level |
| sw_en | output | 1 | Switching allowed |
| drv | output | 1 | Gated drive |
| fault_cause | output | 3 | Cause code of the latest fault |

## Verification
The counts for over-current and over-voltage can reach their limit in the same cycle. So can the counts for over-voltage and line stop. The bench builds both pairs on purpose, with the two flags raised together for three cycles. It then checks that the recorded cause is the lower code. Constrained-random cycles also set several flags at once, and a bench model predicts whether each cycle ends in a fault and which cause wins. Separately, over-temperature is raised during a drive pulse, and `drv` is judged in that same clock.

// File: rtl/flyback_fault_seq.sv
module flyback_fault_seq #(
  parameter int CLK_MHZ     = 125,
  parameter int CSWIN_NS    = 5000,
  parameter int QUAL_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovp_flag,
  input  logic       line_run,
  input  logic       line_stop,
  input  logic       ocp_flag,
  input  logic       cs_min,
  input  logic       otp_flag,
  input  logic       drv_req,
  input  logic       blank_done,
  input  logic       demag_end,
  input  logic       vdd_on,
  input  logic       vdd_off,
  output logic       sw_en,
  output logic       drv,
  output logic [2:0] fault_cause
);
  localparam int WIN = CLK_MHZ * CSWIN_NS / 1000;
  localparam int TW  = $clog2(WIN + 1);
  localparam int QW  = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_CYCLES - 1);

  typedef enum logic [1:0] {ST_WAIT_ON, ST_RUN, ST_HALT} st_t;
  st_t st;

  logic          drv_q, first_pend, chk_act, line_ok, oc_win;
  logic          ov_s, oc_s, run_s, stop_s;
  logic [TW-1:0] chk_t;
  logic [QW-1:0] ov_cnt, oc_cnt, uv_cnt, win_cnt;
  logic [2:0]    cause_nxt;

  wire run_st   = (st == ST_RUN);
  wire cyc_end  = run_st & demag_end;
  wire ov_hit   = ov_s | ovp_flag;
  wire run_hit  = run_s | line_run;
  wire stop_hit = stop_s | line_stop;
  wire rise     = run_st & drv_req & ~drv_q;

  wire ot_trip = run_st & otp_flag;
  wire sh_trip = run_st & chk_act & (chk_t == TW'(WIN));
  wire oc_trip = cyc_end & oc_s & (oc_cnt == QLAST);
  wire ov_trip = cyc_end & ov_hit & (ov_cnt == QLAST);
  wire uv_trip = cyc_end & (line_ok ? (stop_hit & (uv_cnt == QLAST))
                                    : (~run_hit & (win_cnt == QLAST)));
  wire fault_now = ot_trip | sh_trip | oc_trip | ov_trip | uv_trip;
  wire idle      = ~run_st | fault_now;

  assign sw_en = run_st;
  assign drv   = drv_req & run_st & ~fault_now;

  always_comb begin
    if (ot_trip)      cause_nxt = 3'd1;
    else if (sh_trip) cause_nxt = 3'd2;
    else if (oc_trip) cause_nxt = 3'd3;
    else if (ov_trip) cause_nxt = 3'd4;
    else              cause_nxt = 3'd5;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_WAIT_ON;
      fault_cause <= 3'd0;
      first_pend  <= 1'b1;
      drv_q       <= 1'b0;
    end else begin
      drv_q <= drv_req;
      if (fault_now) begin
        st          <= ST_HALT;
        fault_cause <= cause_nxt;
        if (chk_act) first_pend <= 1'b0;
      end else begin
        case (st)
          ST_WAIT_ON: if (vdd_on) st <= ST_RUN;
          ST_HALT:    if (vdd_off) st <= ST_WAIT_ON;
          ST_RUN:     if (chk_act ? cs_min : (rise & first_pend & cs_min)) first_pend <= 1'b0;
          default:    st <= ST_WAIT_ON;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ov_s, oc_s, run_s, stop_s, oc_win, line_ok, chk_act} <= '0;
      {ov_cnt, oc_cnt, uv_cnt, win_cnt} <= '0;
      chk_t <= '0;
    end else if (idle) begin
      {ov_s, oc_s, run_s, stop_s, oc_win, line_ok, chk_act} <= '0;
      {ov_cnt, oc_cnt, uv_cnt, win_cnt} <= '0;
      chk_t <= '0;
    end else begin
      if (cyc_end) begin
        {ov_s, oc_s, run_s, stop_s, oc_win} <= '0;
        ov_cnt <= ov_hit ? ov_cnt + 1'b1 : '0;
        oc_cnt <= oc_s ? oc_cnt + 1'b1 : '0;
        if (line_ok) begin
          uv_cnt <= stop_hit ? uv_cnt + 1'b1 : '0;
        end else begin
          if (run_hit) line_ok <= 1'b1;
          if (win_cnt != QLAST) win_cnt <= win_cnt + 1'b1;
        end
      end else begin
        ov_s   <= ov_hit;
        run_s  <= run_hit;
        stop_s <= stop_hit;
        oc_s   <= oc_s | (oc_win & ocp_flag);
        if (blank_done) oc_win <= 1'b1;
      end
      if (chk_act) begin
        if (cs_min) chk_act <= 1'b0;
        else        chk_t   <= chk_t + 1'b1;
      end else if (rise & first_pend & ~cs_min) begin
        chk_act <= 1'b1;
        chk_t   <= TW'(1);
      end
    end
  end
endmodule

// File: rtl/flyback_fault_seq_chk.sv
module flyback_fault_seq_chk #(
  parameter int QW = 2,
  parameter int Q  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_en,
  input logic          drv,
  input logic          drv_req,
  input logic          otp_flag,
  input logic          vdd_on,
  input logic [2:0]    fault_cause,
  input logic [QW-1:0] ov_cnt,
  input logic [QW-1:0] oc_cnt,
  input logic [QW-1:0] uv_cnt
);
  a_r3_drv_gated: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> (drv_req && sw_en));

  a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en && !vdd_on) |=> !sw_en);

  a_r11_cause_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> (fault_cause != 3'd0 && fault_cause <= 3'd5));

  a_r10_otp_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && otp_flag) |-> !drv);

  a_r10_otp_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && otp_flag) |=> (!sw_en && fault_cause == 3'd1));

  a_r12_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_cnt < QW'(Q)) && (oc_cnt < QW'(Q)) && (uv_cnt < QW'(Q)));

  a_r12_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> (ov_cnt == '0 && oc_cnt == '0 && uv_cnt == '0));
endmodule

bind flyback_fault_seq flyback_fault_seq_chk #(.QW(QW), .Q(QUAL_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .drv(drv), .drv_req(drv_req),
  .otp_flag(otp_flag), .vdd_on(vdd_on), .fault_cause(fault_cause),
  .ov_cnt(ov_cnt), .oc_cnt(oc_cnt), .uv_cnt(uv_cnt)
);

// File: tb/test_flyback_fault_seq.sv
module test_flyback_fault_seq;
  localparam int WIN = 625;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovp_flag = 0, line_run = 0, line_stop = 0, ocp_flag = 0, cs_min = 0, otp_flag = 0;
  logic drv_req = 0, blank_done = 0, demag_end = 0, vdd_on = 0, vdd_off = 0;
  logic sw_en, drv;
  logic [2:0] fault_cause;

  int n_tests = 0, n_fail = 0;
  int m_ov, m_oc, m_uv, m_win;
  bit m_lineok;

  always #4 clk = ~clk;

  flyback_fault_seq i_flyback_fault_seq (
    .clk(clk), .rst_n(rst_n), .ovp_flag(ovp_flag), .line_run(line_run),
    .line_stop(line_stop), .ocp_flag(ocp_flag), .cs_min(cs_min), .otp_flag(otp_flag),
    .drv_req(drv_req), .blank_done(blank_done), .demag_end(demag_end),
    .vdd_on(vdd_on), .vdd_off(vdd_off), .sw_en(sw_en), .drv(drv), .fault_cause(fault_cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_ov = 0; m_oc = 0; m_uv = 0; m_win = 0; m_lineok = 0;
  endtask

  function automatic int cause_of(input bit oct, input bit ovt, input bit uvt);
    if (oct) return 3;
    if (ovt) return 4;
    if (uvt) return 5;
    return 0;
  endfunction

  task automatic model_cycle(input bit ov, input bit run, input bit stop, input bit oc,
                             output bit flt, output int cause);
    bit ovt, oct, uvt;
    ovt = ov && m_ov == 2;
    oct = oc && m_oc == 2;
    uvt = m_lineok ? (stop && m_uv == 2) : (!run && m_win == 2);
    flt = ovt | oct | uvt;
    cause = cause_of(oct, ovt, uvt);
    if (flt) model_clear();
    else begin
      m_ov = ov ? m_ov + 1 : 0;
      m_oc = oc ? m_oc + 1 : 0;
      if (m_lineok) m_uv = stop ? m_uv + 1 : 0;
      else begin
        if (run) m_lineok = 1;
        if (m_win < 2) m_win++;
      end
    end
  endtask

  task automatic pulse_on();
    @(negedge clk) vdd_on = 1;
    @(negedge clk) vdd_on = 0;
    #1;
  endtask

  task automatic pulse_off();
    @(negedge clk) vdd_off = 1;
    @(negedge clk) vdd_off = 0;
    #1;
  endtask

  task automatic do_reset();
    {ovp_flag, line_run, line_stop, ocp_flag, cs_min, otp_flag} = '0;
    {drv_req, blank_done, demag_end, vdd_on, vdd_off} = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_clear();
  endtask

  task automatic restart(input string req);
    pulse_on();
    chk({req, " R2 vdd_on ignored before vdd_off"}, sw_en, 0);
    pulse_off();
    chk({req, " R2 still halted after vdd_off"}, sw_en, 0);
    pulse_on();
    chk({req, " R2 resumes on vdd_on"}, sw_en, 1);
    model_clear();
  endtask

  task automatic sw_cycle(input bit ov, input bit run, input bit stop, input bit oc,
                          input bit early, input bit late, input string req);
    bit flt;
    int cause;
    model_cycle(ov, run, stop, oc, flt, cause);
    @(negedge clk);
    drv_req = 1; cs_min = 1; ovp_flag = ov; line_run = run; line_stop = stop; ocp_flag = early;
    #1 chk({req, " R3 drv follows drv_req"}, drv, 1);
    @(negedge clk) cs_min = 0; blank_done = 1;
    @(negedge clk) blank_done = 0; ocp_flag = oc;
    @(negedge clk) ocp_flag = 0; drv_req = 0;
    @(negedge clk) demag_end = 1; ocp_flag = late;
    @(negedge clk) demag_end = 0; ocp_flag = 0; ovp_flag = 0; line_run = 0; line_stop = 0;
    #1 chk({req, " sw_en after cycle"}, sw_en, flt ? 0 : 1);
    if (flt) begin
      chk({req, " R11 cause"}, fault_cause, cause);
      restart(req);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state, drive blocked while waiting
    drv_req = 1; #1;
    chk("R1 sw_en", sw_en, 0);
    chk("R1 drv", drv, 0);
    chk("R1 cause", fault_cause, 0);
    drv_req = 0;
    pulse_on();
    chk("R2 start on vdd_on", sw_en, 1);

    // R4 over-voltage run broken then completed
    sw_cycle(1, 1, 0, 0, 0, 0, "R4 ov 1");
    sw_cycle(1, 1, 0, 0, 0, 0, "R4 ov 2");
    sw_cycle(0, 1, 0, 0, 0, 0, "R4 gap");
    sw_cycle(1, 1, 0, 0, 0, 0, "R4 ov a");
    sw_cycle(1, 1, 0, 0, 0, 0, "R4 ov b");
    sw_cycle(1, 1, 0, 0, 0, 0, "R4 ov trip");

    // R5 start-up window: pass on third cycle, then fail
    sw_cycle(0, 0, 0, 0, 0, 0, "R5 no run 1");
    sw_cycle(0, 0, 1, 0, 0, 0, "R5 no run 2");
    sw_cycle(0, 1, 0, 0, 0, 0, "R5 run on third");
    sw_cycle(0, 0, 0, 0, 0, 0, "R5 after pass");
    restart_line_fail();

    // R6 line stop
    sw_cycle(0, 1, 0, 0, 0, 0, "R6 arm");
    sw_cycle(0, 0, 1, 0, 0, 0, "R6 stop 1");
    sw_cycle(0, 0, 1, 0, 0, 0, "R6 stop 2");
    sw_cycle(0, 0, 1, 0, 0, 0, "R6 stop trip");

    // R7 over-current outside window ignored, R8 inside trips
    sw_cycle(0, 1, 0, 0, 1, 1, "R7 outside 1");
    sw_cycle(0, 1, 0, 0, 1, 1, "R7 outside 2");
    sw_cycle(0, 1, 0, 0, 1, 1, "R7 outside 3");
    sw_cycle(0, 1, 0, 1, 0, 0, "R8 oc 1");
    sw_cycle(0, 1, 0, 1, 0, 0, "R8 oc 2");
    sw_cycle(0, 1, 0, 1, 0, 0, "R8 oc trip");

    // R11 simultaneous qualification
    sw_cycle(1, 1, 0, 1, 0, 0, "R11 oc+ov 1");
    sw_cycle(1, 1, 0, 1, 0, 0, "R11 oc+ov 2");
    sw_cycle(1, 1, 0, 1, 0, 0, "R11 oc+ov trip");
    sw_cycle(0, 1, 0, 0, 0, 0, "R11 arm");
    sw_cycle(1, 1, 1, 0, 0, 0, "R11 ov+line 1");
    sw_cycle(1, 1, 1, 0, 0, 0, "R11 ov+line 2");
    sw_cycle(1, 1, 1, 0, 0, 0, "R11 ov+line trip");

    // R10 / R12 over-temperature mid-pulse, repeat while hot, counts cleared
    sw_cycle(1, 1, 0, 0, 0, 0, "R12 ov pre 1");
    sw_cycle(1, 1, 0, 0, 0, 0, "R12 ov pre 2");
    @(negedge clk) drv_req = 1;
    #1 chk("R10 drv before otp", drv, 1);
    otp_flag = 1;
    #1 chk("R10 drv cut same clock", drv, 0);
    @(negedge clk) drv_req = 0;
    #1 chk("R10 halted", sw_en, 0);
    chk("R10 cause", fault_cause, 1);
    pulse_off();
    pulse_on();
    chk("R10 resumes briefly", sw_en, 1);
    @(negedge clk) #1;
    chk("R10 repeats while hot", sw_en, 0);
    chk("R10 cause again", fault_cause, 1);
    otp_flag = 0;
    pulse_off();
    pulse_on();
    chk("R10 resumes when cool", sw_en, 1);
    model_clear();
    sw_cycle(1, 1, 0, 0, 0, 0, "R12 ov fresh 1");
    sw_cycle(1, 1, 0, 0, 0, 0, "R12 ov fresh 2");
    sw_cycle(1, 1, 0, 0, 0, 0, "R12 ov fresh trip");

    // R9 current-sense minimum missing on first pulse
    do_reset();
    pulse_on();
    @(negedge clk) drv_req = 1; cs_min = 0;
    repeat (WIN - 1) @(negedge clk);
    #1 chk("R9 drv high at window end", drv, 1);
    @(negedge clk) #1;
    chk("R9 drv cut after window", drv, 0);
    @(negedge clk) drv_req = 0;
    #1 chk("R9 halted", sw_en, 0);
    chk("R9 cause", fault_cause, 2);
    restart("R9");
    @(negedge clk) drv_req = 1;
    repeat (WIN + 10) @(negedge clk);
    #1 chk("R9 later pulse unchecked", drv, 1);
    chk("R9 later pulse sw_en", sw_en, 1);
    drv_req = 0;

    // R9 cs_min in last clock of window passes
    do_reset();
    pulse_on();
    @(negedge clk) drv_req = 1;
    repeat (WIN - 1) @(negedge clk);
    cs_min = 1;
    @(negedge clk) cs_min = 0;
    #1 chk("R9 late cs_min drv", drv, 1);
    repeat (5) @(negedge clk);
    #1 chk("R9 late cs_min sw_en", sw_en, 1);
    drv_req = 0;

    // random mix
    for (int i = 0; i < 300; i++) begin
      sw_cycle(($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 4) == 0,
               ($urandom % 4) == 0, ($urandom % 2) == 1, ($urandom % 2) == 1, "rand R4 R6 R8");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic restart_line_fail();
    bit flt;
    int cause;
    model_cycle(0, 0, 0, 0, flt, cause);
    chk("R5 model precondition", flt, 0);
    sw_cycle(1, 1, 0, 0, 0, 0, "R5 filler");
    model_clear();
    pulse_vdd_cycle();
  endtask

  task automatic pulse_vdd_cycle();
    @(negedge clk) otp_flag = 1;
    @(negedge clk) otp_flag = 0;
    #1 chk("R5 forced restart", sw_en, 0);
    restart("R5");
    sw_cycle(0, 0, 0, 0, 0, 0, "R5 miss 1");
    sw_cycle(0, 0, 0, 0, 0, 0, "R5 miss 2");
    sw_cycle(0, 0, 0, 0, 0, 0, "R5 miss trip");
  endtask
endmodule